// File: doc/BRIEF.md
# Two-Signal Timed Edge Sequencer

The block drives two single-bit outputs, `sig_a` and `sig_b`, through a four-edge pattern that repeats without pause. Each pattern cycle starts with both outputs high. Then `sig_b` falls, `sig_a` falls, `sig_b` rises and `sig_a` rises, and the next cycle begins at once. The time to each edge is a number of clock cycles. Software supplies that number through a requested delay for each interval. It also supplies a lower and an upper bound for each interval. The block samples the delay when the step begins and clamps it into the bound window.

Two elapsed-time counters, one per output, set the timing, and they restart at interleaved points. The b-fall edge and the a-fall edge are both timed from the start of the cycle. The a counter restarts when `sig_a` falls. The b-rise edge is still timed by the b counter, which has run since the cycle started. The a-rise edge is timed from the a-fall edge. Both counters restart when `sig_a` rises.

At the start of every cycle the bound rules of all four intervals are checked. A violation raises a sticky error and parks the block with both outputs high. Each output edge is also reported on a one-cycle strobe.

Top module: `edge_pattern_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sig_a` and `sig_b` are 1. `cnt_a`, `cnt_b`, all four strobes, `cfg_err` and `delay_clamped` are 0.
- R2: Edges occur only in this order: `sig_b` falls, then `sig_a` falls, then `sig_b` rises, then `sig_a` rises, and then the order repeats.
- R3: A pattern cycle starts on the clock edge after reset is released, and again on every `sig_a` rise. At that point both counters are 0 and the delay for interval 0 (b fall) is sampled. `sig_b` falls on the edge at which `cnt_b` reaches that delay, so in the first low cycle `cnt_b` equals the delay.
- R4: `sig_a` falls when `cnt_a` reaches the interval-1 delay, counted from the start of the cycle. If the count has already passed that delay when the step begins, `sig_a` falls on the first edge of the step. The b-fall edge clears neither counter.
- R5: `cnt_a` reads 0 in the first cycle `sig_a` is low. `sig_b` rises when `cnt_b`, still counting from the start of the cycle, reaches the interval-2 delay, or on the first edge of the step if that value has already passed.
- R6: `sig_a` rises when `cnt_a`, counting from the a-fall edge, reaches the interval-3 delay. In the first cycle `sig_a` is high again, both counters read 0 and the next cycle has begun.
- R7: At every cycle start, each interval k (0 = b fall, 1 = a fall, 2 = b rise, 3 = a rise) must have `lo_bound[k]` > 0 and `lo_bound[k]` <= `hi_bound[k]`. On a violation, `cfg_err` goes to 1 and stays 1 until reset. Both outputs then stay 1, both counters stay 0 and no further strobe fires.
- R8: The delay for interval k is sampled from `delay[k]` only as step k begins. A later change of `delay[k]` has no effect on that step.
- R9: The sampled delay is clamped: below `lo_bound[k]` it becomes `lo_bound[k]`, and above `hi_bound[k]` it becomes `hi_bound[k]`. `delay_clamped` shows, from the step's first cycle, whether the current step's delay was clamped.
- R10: `a_rise`, `a_fall`, `b_rise` and `b_fall` are each high for exactly the one cycle in which the matching output first shows its new value.
- R11: Both counters saturate at 2^CW-1 and never wrap while counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_bound | input | 4*CW | Lower bound per interval, index k as in R7 |
| hi_bound | input | 4*CW | Upper bound per interval |
| delay | input | 4*CW | Requested delay per interval |
| sig_a | output | 1 | Output a |
| sig_b | output | 1 | Output b |
| a_rise | output | 1 | Strobe for a rising |
| a_fall | output | 1 | Strobe for a falling |
| b_rise | output | 1 | Strobe for b rising |
| b_fall | output | 1 | Strobe for b falling |
| cnt_a | output | CW | Elapsed counter a |
| cnt_b | output | CW | Elapsed counter b |
| delay_clamped | output | 1 | Current step's delay was clamped |
| cfg_err | output | 1 | Sticky bound-rule error |

## Verification
The bench sets up orderings in which a step begins after its target count has already passed. In that case the a fall or the b rise must fire on the step's first edge. A design that compares for equality instead would wait for the counter to wrap around. A long a-fall delay drives `cnt_b` to its ceiling, so a counter that wraps shows up as a 0. Delays are changed in the middle of a step and set outside the bound window. These patterns expose a design that samples the delay continuously or clamps the wrong side. Bound violations, both a zero lower bound and a crossed window, must latch the error and freeze the outputs high even after the configuration is repaired.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NSTEP  = 4;
  localparam int STEP_W = $clog2(NSTEP);

  // interval indices; the order is the edge order of a pattern cycle
  localparam logic [STEP_W-1:0] IV_BFALL = 2'd0;
  localparam logic [STEP_W-1:0] IV_AFALL = 2'd1;
  localparam logic [STEP_W-1:0] IV_BRISE = 2'd2;
  localparam logic [STEP_W-1:0] IV_ARISE = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BFALL,
    ST_AFALL,
    ST_BRISE,
    ST_ARISE,
    ST_HALT
  } seq_state_e;
endpackage

// File: rtl/seq_bound_check.sv
module seq_bound_check #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hi_i,
  output logic          ok_o
);
  // window must be non-empty and start above zero
  always_comb begin
    ok_o = (lo_i != '0) && (lo_i <= hi_i);
  end
endmodule

// File: rtl/seq_delay_clamp.sv
module seq_delay_clamp #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hi_i,
  input  logic [CW-1:0] req_i,
  output logic [CW-1:0] val_o,
  output logic          clip_o
);
  always_comb begin
    if (req_i < lo_i) begin
      val_o  = lo_i;
      clip_o = 1'b1;
    end else if (req_i > hi_i) begin
      val_o  = hi_i;
      clip_o = 1'b1;
    end else begin
      val_o  = req_i;
      clip_o = 1'b0;
    end
  end

  // R9: a valid window always yields a value inside it
  always_comb begin
    if (lo_i <= hi_i) begin
      a_r9_in_window: assert (val_o >= lo_i && val_o <= hi_i);
    end
  end
endmodule

// File: rtl/seq_elapsed_ctr.sv
module seq_elapsed_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o <= '0;
    end else if (run_i && cnt_o != CMAX) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  // R11: a full counter holds its value unless cleared
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == CMAX && !clr_i) |=> (cnt_o == CMAX));
endmodule

// File: rtl/edge_pattern_seq.sv
module edge_pattern_seq
  import seq_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NSTEP-1:0][CW-1:0]   lo_bound,
  input  logic [NSTEP-1:0][CW-1:0]   hi_bound,
  input  logic [NSTEP-1:0][CW-1:0]   delay,
  output logic                       sig_a,
  output logic                       sig_b,
  output logic                       a_rise,
  output logic                       a_fall,
  output logic                       b_rise,
  output logic                       b_fall,
  output logic [CW-1:0]              cnt_a,
  output logic [CW-1:0]              cnt_b,
  output logic                       delay_clamped,
  output logic                       cfg_err
);
  seq_state_e        state_q, state_d;
  logic [CW-1:0]     tgt_q;
  logic [NSTEP-1:0]  ok_vec;
  logic [NSTEP-1:0]  clip_vec;
  logic [CW-1:0]     clamp_val [NSTEP];
  logic              cfg_ok;

  // per-interval bound rule and clamp
  for (genvar k = 0; k < NSTEP; k++) begin : g_iv
    seq_bound_check #(.CW(CW)) u_chk (
      .lo_i (lo_bound[k]),
      .hi_i (hi_bound[k]),
      .ok_o (ok_vec[k])
    );
    seq_delay_clamp #(.CW(CW)) u_clamp (
      .lo_i   (lo_bound[k]),
      .hi_i   (hi_bound[k]),
      .req_i  (delay[k]),
      .val_o  (clamp_val[k]),
      .clip_o (clip_vec[k])
    );
  end

  assign cfg_ok = &ok_vec;

  // edge detection: the counter that times the current step
  logic [CW-1:0] sel_cnt;
  logic [CW:0]   sel_next;
  logic          fire;

  always_comb begin
    unique case (state_q)
      ST_AFALL, ST_ARISE: sel_cnt = cnt_a;
      default:            sel_cnt = cnt_b;
    endcase
    sel_next = {1'b0, sel_cnt} + {{CW{1'b0}}, 1'b1};
    fire     = (sel_next >= {1'b0, tgt_q});
  end

  // next-state and event decode
  logic              ld_en;
  logic [STEP_W-1:0] ld_idx;
  logic              ev_bf, ev_af, ev_br, ev_ar, err_set;

  always_comb begin
    state_d = state_q;
    ld_en   = 1'b0;
    ld_idx  = IV_BFALL;
    ev_bf   = 1'b0;
    ev_af   = 1'b0;
    ev_br   = 1'b0;
    ev_ar   = 1'b0;
    err_set = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cfg_ok) begin
          state_d = ST_BFALL;
          ld_en   = 1'b1;
          ld_idx  = IV_BFALL;
        end else begin
          state_d = ST_HALT;
          err_set = 1'b1;
        end
      end
      ST_BFALL: begin
        if (fire) begin
          ev_bf   = 1'b1;
          state_d = ST_AFALL;
          ld_en   = 1'b1;
          ld_idx  = IV_AFALL;
        end
      end
      ST_AFALL: begin
        if (fire) begin
          ev_af   = 1'b1;
          state_d = ST_BRISE;
          ld_en   = 1'b1;
          ld_idx  = IV_BRISE;
        end
      end
      ST_BRISE: begin
        if (fire) begin
          ev_br   = 1'b1;
          state_d = ST_ARISE;
          ld_en   = 1'b1;
          ld_idx  = IV_ARISE;
        end
      end
      ST_ARISE: begin
        if (fire) begin
          ev_ar = 1'b1;
          if (cfg_ok) begin
            state_d = ST_BFALL;
            ld_en   = 1'b1;
            ld_idx  = IV_BFALL;
          end else begin
            state_d = ST_HALT;
            err_set = 1'b1;
          end
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  // counters
  logic run_cnt;
  assign run_cnt = (state_q == ST_BFALL) || (state_q == ST_AFALL) ||
                   (state_q == ST_BRISE) || (state_q == ST_ARISE);

  seq_elapsed_ctr #(.CW(CW)) u_ctr_a (
    .clk   (clk),
    .rst   (rst),
    .clr_i (ev_af | ev_ar),
    .run_i (run_cnt),
    .cnt_o (cnt_a)
  );

  seq_elapsed_ctr #(.CW(CW)) u_ctr_b (
    .clk   (clk),
    .rst   (rst),
    .clr_i (ev_ar),
    .run_i (run_cnt),
    .cnt_o (cnt_b)
  );

  // registered state and outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      tgt_q         <= '0;
      sig_a         <= 1'b1;
      sig_b         <= 1'b1;
      a_rise        <= 1'b0;
      a_fall        <= 1'b0;
      b_rise        <= 1'b0;
      b_fall        <= 1'b0;
      delay_clamped <= 1'b0;
      cfg_err       <= 1'b0;
    end else begin
      state_q <= state_d;
      a_rise  <= ev_ar;
      a_fall  <= ev_af;
      b_rise  <= ev_br;
      b_fall  <= ev_bf;
      if (ld_en) begin
        tgt_q         <= clamp_val[ld_idx];
        delay_clamped <= clip_vec[ld_idx];
      end
      if (ev_bf) sig_b <= 1'b0;
      if (ev_br) sig_b <= 1'b1;
      if (ev_af) sig_a <= 1'b0;
      if (ev_ar) sig_a <= 1'b1;
      if (err_set) cfg_err <= 1'b1;
    end
  end

  // R2: edge ordering
  a_r2_bfall_while_a_high: assert property (@(posedge clk) disable iff (rst)
    $fell(sig_b) |-> sig_a);
  a_r2_afall_while_b_low: assert property (@(posedge clk) disable iff (rst)
    $fell(sig_a) |-> !sig_b);
  a_r2_brise_while_a_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sig_b) |-> !sig_a);
  a_r2_arise_while_b_high: assert property (@(posedge clk) disable iff (rst)
    $rose(sig_a) |-> sig_b);
  // R5 / R6: counter restarts
  a_r5_cnt_a_cleared_on_afall: assert property (@(posedge clk) disable iff (rst)
    $fell(sig_a) |-> (cnt_a == '0));
  a_r6_both_cleared_on_arise: assert property (@(posedge clk) disable iff (rst)
    $rose(sig_a) |-> (cnt_a == '0 && cnt_b == '0));
  // R7: sticky error, parked outputs
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
  a_r7_err_parked: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_err) |-> (sig_a && sig_b && cnt_a == '0 && cnt_b == '0 &&
                        !a_fall && !b_fall && !a_rise && !b_rise));
  // R10: strobes track output changes
  a_r10_bfall_strobe: assert property (@(posedge clk) disable iff (rst)
    b_fall == $fell(sig_b));
  a_r10_afall_strobe: assert property (@(posedge clk) disable iff (rst)
    a_fall == $fell(sig_a));
  a_r10_brise_strobe: assert property (@(posedge clk) disable iff (rst)
    b_rise == $rose(sig_b));
  a_r10_arise_strobe: assert property (@(posedge clk) disable iff (rst)
    a_rise == $rose(sig_a));
endmodule

// File: tb/edge_pattern_seq_bench.sv
`timescale 1ns/1ps
module edge_pattern_seq_bench;
  localparam int CW   = 8;
  localparam int NS   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0][CW-1:0] lo, hi, dly;
  logic sig_a, sig_b, a_rise, a_fall, b_rise, b_fall, delay_clamped, cfg_err;
  logic [CW-1:0] cnt_a, cnt_b;

  always #2.5 clk = ~clk;

  edge_pattern_seq #(.CW(CW)) u_edge_pattern_seq (
    .clk(clk), .rst(rst), .lo_bound(lo), .hi_bound(hi), .delay(dly),
    .sig_a(sig_a), .sig_b(sig_b), .a_rise(a_rise), .a_fall(a_fall),
    .b_rise(b_rise), .b_fall(b_fall), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .delay_clamped(delay_clamped), .cfg_err(cfg_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  string phase = "R1 reset";
  bit started = 0;

  // ---------- behavioural reference ----------
  // mode: 0 waiting for first cycle, 1..4 waiting for edge k-1, 5 parked
  int mode, ca, cb, tgt;
  bit ma, mb, mbf, maf, mbr, mar, merr, mcl;

  function automatic bit rules_met();
    for (int k = 0; k < NS; k++)
      if (lo[k] == 0 || lo[k] > hi[k]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic take_delay(int k);
    int l = lo[k];
    int h = hi[k];
    int d = dly[k];
    if (d < l)      begin tgt = l; mcl = 1; end
    else if (d > h) begin tgt = h; mcl = 1; end
    else            begin tgt = d; mcl = 0; end
  endtask

  task automatic new_cycle();
    ca = 0; cb = 0;
    if (!rules_met()) begin merr = 1; mode = 5; end
    else begin mode = 1; take_delay(0); end
  endtask

  function automatic int tick(int v);
    return (v < CMAX) ? v + 1 : CMAX;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mode = 0; ca = 0; cb = 0; tgt = 0;
      ma = 1; mb = 1; mbf = 0; maf = 0; mbr = 0; mar = 0; merr = 0; mcl = 0;
    end else begin
      mbf = 0; maf = 0; mbr = 0; mar = 0;
      case (mode)
        0: new_cycle();
        1: begin
          ca = tick(ca); cb = tick(cb);
          if (cb >= tgt) begin mb = 0; mbf = 1; mode = 2; take_delay(1); end
        end
        2: begin
          ca = tick(ca); cb = tick(cb);
          if (ca >= tgt) begin ma = 0; maf = 1; ca = 0; mode = 3; take_delay(2); end
        end
        3: begin
          ca = tick(ca); cb = tick(cb);
          if (cb >= tgt) begin mb = 1; mbr = 1; mode = 4; take_delay(3); end
        end
        4: begin
          ca = tick(ca); cb = tick(cb);
          if (ca >= tgt) begin ma = 1; mar = 1; new_cycle(); end
        end
        default: ;
      endcase
    end
    started = 1;
  end

  task automatic cmp(string what, string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d at %0t", req, phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cmp("sig_a", "R2", sig_a, ma);
      cmp("sig_b", "R2", sig_b, mb);
      cmp("b_fall", "R10", b_fall, mbf);
      cmp("a_fall", "R10", a_fall, maf);
      cmp("b_rise", "R10", b_rise, mbr);
      cmp("a_rise", "R10", a_rise, mar);
      cmp("cnt_a", "R5", cnt_a, ca);
      cmp("cnt_b", "R3", cnt_b, cb);
      cmp("cfg_err", "R7", cfg_err, merr);
      cmp("delay_clamped", "R9", delay_clamped, mcl);
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_iv(int k, int l, int h, int d);
    lo[k] = l[CW-1:0]; hi[k] = h[CW-1:0]; dly[k] = d[CW-1:0];
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst = 1; wait_n(3); rst = 0;
  endtask

  initial begin
    for (int k = 0; k < NS; k++) set_iv(k, 1, 60, 5);
    // R1: reset state held, then released
    phase = "R1 reset";
    wait_n(4);
    rst = 0;
    wait_n(1);

    // R2 R3 R4 R5 R6 R10: nominal pattern, edges spaced out
    phase = "R2 R3 R4 R5 R6 R10 nominal";
    set_iv(0, 1, 60, 4); set_iv(1, 1, 60, 9); set_iv(2, 1, 60, 14); set_iv(3, 1, 60, 6);
    wait_n(90);

    // R4 R5: a-fall and b-rise targets already passed when their step starts
    phase = "R4 R5 overtaken targets";
    set_iv(0, 1, 60, 10); set_iv(1, 1, 60, 3); set_iv(2, 1, 60, 2); set_iv(3, 1, 60, 5);
    wait_n(80);

    // R9: requests below and above the window
    phase = "R9 clamp";
    set_iv(0, 2, 50, 0); set_iv(1, 3, 50, 12); set_iv(2, 1, 20, 99); set_iv(3, 4, 9, 30);
    wait_n(120);

    // R8: delays change while steps are in progress
    phase = "R8 mid-step changes";
    for (int i = 0; i < 25; i++) begin
      for (int k = 0; k < NS; k++) dly[k] = CW'(((i * 7 + k * 5) % 17) + 1);
      lo = '{default: 8'd1}; hi = '{default: 8'd40};
      wait_n(7);
    end

    // R11: long a-fall delay pushes cnt_b to its ceiling
    phase = "R11 saturation";
    set_iv(0, 1, 255, 5); set_iv(1, 1, 255, 255); set_iv(2, 1, 255, 10); set_iv(3, 1, 255, 20);
    wait_n(620);

    // R7: zero lower bound mid-run, then repaired (error stays)
    phase = "R7 zero lower bound";
    set_iv(0, 1, 30, 3); set_iv(1, 1, 30, 6); set_iv(2, 1, 30, 8); set_iv(3, 1, 30, 4);
    wait_n(5);
    lo[2] = '0;
    wait_n(40);
    lo[2] = 8'd1;
    wait_n(30);

    // R1: reset clears the error
    phase = "R1 reset after error";
    pulse_reset();
    wait_n(30);

    // R7: crossed window at reset release
    phase = "R7 crossed window";
    set_iv(1, 8, 3, 5);
    pulse_reset();
    wait_n(30);

    summary();
    $finish;
  end
endmodule